// File: doc/BRIEF.md
# Framed Link Receiver

The block receives a 16-bit parallel symbol stream from a serializer/deserializer front end. Each symbol has two byte lanes and a control flag per lane. The block sorts each symbol into data or one of the control codes. It recovers packets that are bracketed by start and end control words and joins pairs of 16-bit halves into 32-bit words. It checks the 16-bit CRC word that follows the end marker, and it delivers each word with start, end and error flags. In-band flow-control codes become single-cycle pulses. A lost input signal and error or unknown control codes are flagged on their own outputs.

A framing state machine drives the block. Its states are `ST_HUNT`, which waits for a start marker; `ST_LOW`, which expects the low half of a word; `ST_HIGH`, which expects the high half; and `ST_CRC`, which expects the CRC word.

The transitions are:
- Start: `ST_HUNT` to `ST_LOW` on a start marker. This presets the CRC.
- Low taken: `ST_LOW` to `ST_HIGH` on a data symbol.
- High taken: `ST_HIGH` to `ST_LOW` on a data symbol.
- End: `ST_LOW` to `ST_CRC` on an end marker.
- Check: `ST_CRC` to `ST_HUNT` on a data symbol. This closes the packet.
- Abort: any in-packet state to `ST_HUNT` on an illegal symbol.
- Skip: idle, XON and XOFF leave every state unchanged.

Every completed 32-bit word is held back for one word. This lets the last word carry the end flag and the CRC verdict. All outputs are registered and appear one cycle after the symbol that causes them.

Top module: `lnk_frame_rx`

## Requirements
- R1: Outside a packet (state `ST_HUNT`), data symbols and end markers are discarded, and `out_valid` stays low.
- R2: A start marker is 0xDC in both lanes with both control flags set. In a packet, each output word is two data symbols with both flags clear. The low half comes first. `out_data[15:0]` is the first symbol and `out_data[31:16]` is the second, with the lower byte lane as the least significant byte.
- R3: The first word of a packet has `out_sop`=1. The last word has `out_eop`=1 and is output one cycle after the CRC symbol. All flags are low whenever `out_valid` is low.
- R4: The CRC word is the data symbol after the end marker (0x9C in both lanes, both flags set). It is compared with a CRC-16 computed over every data half in arrival order: polynomial 0x1021, preset 0xFFFF, MSB first, no final inversion. The last word carries `out_err`=1 exactly when they differ.
- R5: An idle symbol has the upper flag set with 0xBC, and the lower flag clear with 0xC5. It is skipped in any state without losing half-word alignment.
- R6: XON (0x5C both lanes, both flags) and XOFF (0x7C both lanes, both flags) each raise `xon_pulse` or `xoff_pulse` for one cycle, one cycle after the symbol. Neither is passed on as data, and neither disturbs alignment.
- R7: A lane with its control flag set and byte 0xFF raises `los_flag` one cycle later. Inside a packet, it also aborts the packet.
- R8: A lane with its control flag set and byte 0x00, or any other control symbol not listed in R2 to R7, raises `link_err` one cycle later.
- R9: The packet aborts on any of three symbols: a start marker inside a packet, an end marker after an odd number of halves, or any control symbol other than idle, XON or XOFF. On abort, the held word (if any) is output with `out_eop`=1 and `out_err`=1, and the receiver returns to hunting.
- R10: A packet with no data halves produces no output word.
- R11: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sym | input | 16 | Received symbol, lane 0 in bits 7:0 |
| rx_ctl_lo | input | 1 | Control flag of the lower lane |
| rx_ctl_hi | input | 1 | Control flag of the upper lane |
| out_data | output | 32 | Reassembled data word |
| out_valid | output | 1 | Word valid, one cycle per word |
| out_sop | output | 1 | First word of packet |
| out_eop | output | 1 | Last word of packet |
| out_err | output | 1 | Packet failed CRC or was aborted |
| xon_pulse | output | 1 | XON received |
| xoff_pulse | output | 1 | XOFF received |
| los_flag | output | 1 | Loss-of-signal code received |
| link_err | output | 1 | Error or unknown control code received |

## Verification
Good packets of one to six words are swept. They check the order of the halves and the start and end flags, and they separate a correct hold-back from an early or lost last word. An idle symbol and a flow-control symbol are then placed at every position inside a three-word packet. These sweeps show whether skipping keeps half alignment and whether the pulses leak into the data. Each of the sixteen CRC bits is flipped on its own, which catches a partial or misordered compare. Aborts by every illegal symbol, at even and odd half counts, together with stray symbols while hunting, separate the error paths from the discard path.

// File: rtl/lnk_rx_pkg.sv
package lnk_rx_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int HALF_W = LANE_W * LANES;
    localparam int WORD_W = 2 * HALF_W;
    localparam int CRC_W  = HALF_W;

    localparam logic [LANE_W-1:0] CODE_START   = 8'hDC;
    localparam logic [LANE_W-1:0] CODE_END     = 8'h9C;
    localparam logic [LANE_W-1:0] CODE_XON     = 8'h5C;
    localparam logic [LANE_W-1:0] CODE_XOFF    = 8'h7C;
    localparam logic [LANE_W-1:0] CODE_IDLE_K  = 8'hBC;
    localparam logic [LANE_W-1:0] CODE_IDLE_D  = 8'hC5;
    localparam logic [LANE_W-1:0] CODE_LOS     = 8'hFF;
    localparam logic [LANE_W-1:0] CODE_ERR     = 8'h00;

    typedef enum logic [3:0] {
        SK_DATA,
        SK_IDLE,
        SK_START,
        SK_END,
        SK_XON,
        SK_XOFF,
        SK_LOS,
        SK_ERRK,
        SK_OTHER
    } sym_kind_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_LOW,
        ST_HIGH,
        ST_CRC
    } rx_state_e;

    // One CRC step over a full half-word, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0]  poly,
        input logic [CRC_W-1:0]  crc_in,
        input logic [HALF_W-1:0] din
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int b = HALF_W - 1; b >= 0; b--) begin
            fb = c[CRC_W-1] ^ din[b];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/lnk_sym_class.sv
module lnk_sym_class
    import lnk_rx_pkg::*;
(
    input  logic [HALF_W-1:0] sym,
    input  logic              ctl_lo,
    input  logic              ctl_hi,
    output sym_kind_e         kind
);

    logic [LANES-1:0]  ctl_vec;
    logic [LANES-1:0]  lane_los;
    logic [LANES-1:0]  lane_err;
    logic [LANE_W-1:0] byte_lo;
    logic [LANE_W-1:0] byte_hi;

    assign ctl_vec = {ctl_hi, ctl_lo};
    assign byte_lo = sym[LANE_W-1:0];
    assign byte_hi = sym[HALF_W-1:LANE_W];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_los[i] = ctl_vec[i] && (sym[i*LANE_W +: LANE_W] == CODE_LOS);
        assign lane_err[i] = ctl_vec[i] && (sym[i*LANE_W +: LANE_W] == CODE_ERR);
    end

    always_comb begin
        kind = SK_OTHER;
        if (ctl_vec == '0) begin
            kind = SK_DATA;
        end else if (|lane_los) begin
            kind = SK_LOS;
        end else if (|lane_err) begin
            kind = SK_ERRK;
        end else if (ctl_hi && !ctl_lo && byte_hi == CODE_IDLE_K && byte_lo == CODE_IDLE_D) begin
            kind = SK_IDLE;
        end else if (ctl_hi && ctl_lo && byte_hi == byte_lo) begin
            case (byte_hi)
                CODE_START: kind = SK_START;
                CODE_END:   kind = SK_END;
                CODE_XON:   kind = SK_XON;
                CODE_XOFF:  kind = SK_XOFF;
                default:    kind = SK_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/lnk_crc16.sv
module lnk_crc16
    import lnk_rx_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 16'h1021,
    parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preset,
    input  logic              upd,
    input  logic [HALF_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= INIT;
        end else if (preset) begin
            crc <= INIT;
        end else if (upd) begin
            crc <= crc_step(POLY, crc, din);
        end
    end

endmodule

// File: rtl/lnk_word_pack.sv
module lnk_word_pack
    import lnk_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take_lo,
    input  logic              take_hi,
    input  logic [HALF_W-1:0] din,
    input  logic              close,
    input  logic              close_err,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err
);

    logic [HALF_W-1:0] lo_q;
    logic [WORD_W-1:0] hold_q;
    logic              hold_vld;
    logic              hold_first;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q       <= '0;
            hold_q     <= '0;
            hold_vld   <= 1'b0;
            hold_first <= 1'b0;
            out_data   <= '0;
            out_valid  <= 1'b0;
            out_sop    <= 1'b0;
            out_eop    <= 1'b0;
            out_err    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_err   <= 1'b0;
            if (clear) begin
                hold_vld   <= 1'b0;
                hold_first <= 1'b0;
            end
            if (take_lo) begin
                lo_q <= din;
            end
            if (take_hi) begin
                // the previous word is now known not to be the last one
                if (hold_vld) begin
                    out_valid <= 1'b1;
                    out_sop   <= hold_first;
                    out_data  <= hold_q;
                end
                hold_q     <= {din, lo_q};
                hold_vld   <= 1'b1;
                hold_first <= ~hold_vld;
            end
            if (close) begin
                if (hold_vld) begin
                    out_valid <= 1'b1;
                    out_sop   <= hold_first;
                    out_eop   <= 1'b1;
                    out_err   <= close_err;
                    out_data  <= hold_q;
                end
                hold_vld   <= 1'b0;
                hold_first <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/lnk_frame_rx.sv
module lnk_frame_rx
    import lnk_rx_pkg::*;
#(
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021,
    parameter logic [CRC_W-1:0] CRC_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] rx_sym,
    input  logic              rx_ctl_lo,
    input  logic              rx_ctl_hi,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_err,
    output logic              xon_pulse,
    output logic              xoff_pulse,
    output logic              los_flag,
    output logic              link_err
);

    sym_kind_e        kind;
    rx_state_e        state_q;
    rx_state_e        state_d;
    logic             pkt_start;
    logic             crc_upd;
    logic             take_lo;
    logic             take_hi;
    logic             close;
    logic             close_err;
    logic [CRC_W-1:0] crc_q;

    lnk_sym_class u_class (
        .sym    (rx_sym),
        .ctl_lo (rx_ctl_lo),
        .ctl_hi (rx_ctl_hi),
        .kind   (kind)
    );

    lnk_crc16 #(
        .POLY (CRC_POLY),
        .INIT (CRC_INIT)
    ) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (pkt_start),
        .upd    (crc_upd),
        .din    (rx_sym),
        .crc    (crc_q)
    );

    lnk_word_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (pkt_start),
        .take_lo   (take_lo),
        .take_hi   (take_hi),
        .din       (rx_sym),
        .close     (close),
        .close_err (close_err),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .out_err   (out_err)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and per-symbol controls
    always_comb begin
        state_d   = state_q;
        pkt_start = 1'b0;
        crc_upd   = 1'b0;
        take_lo   = 1'b0;
        take_hi   = 1'b0;
        close     = 1'b0;
        close_err = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (kind == SK_START) begin
                    pkt_start = 1'b1;
                    state_d   = ST_LOW;
                end
            end
            ST_LOW: begin
                case (kind)
                    SK_DATA: begin
                        take_lo = 1'b1;
                        crc_upd = 1'b1;
                        state_d = ST_HIGH;
                    end
                    SK_IDLE, SK_XON, SK_XOFF: ;
                    SK_END:  state_d = ST_CRC;
                    default: begin
                        close     = 1'b1;
                        close_err = 1'b1;
                        state_d   = ST_HUNT;
                    end
                endcase
            end
            ST_HIGH: begin
                case (kind)
                    SK_DATA: begin
                        take_hi = 1'b1;
                        crc_upd = 1'b1;
                        state_d = ST_LOW;
                    end
                    SK_IDLE, SK_XON, SK_XOFF: ;
                    default: begin
                        close     = 1'b1;
                        close_err = 1'b1;
                        state_d   = ST_HUNT;
                    end
                endcase
            end
            ST_CRC: begin
                case (kind)
                    SK_DATA: begin
                        close     = 1'b1;
                        close_err = (rx_sym != crc_q);
                        state_d   = ST_HUNT;
                    end
                    SK_IDLE, SK_XON, SK_XOFF: ;
                    default: begin
                        close     = 1'b1;
                        close_err = 1'b1;
                        state_d   = ST_HUNT;
                    end
                endcase
            end
        endcase
    end

    // link-level indications
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xon_pulse  <= 1'b0;
            xoff_pulse <= 1'b0;
            los_flag   <= 1'b0;
            link_err   <= 1'b0;
        end else begin
            xon_pulse  <= (kind == SK_XON);
            xoff_pulse <= (kind == SK_XOFF);
            los_flag   <= (kind == SK_LOS);
            link_err   <= (kind == SK_ERRK) || (kind == SK_OTHER);
        end
    end

endmodule

// File: rtl/lnk_frame_rx_chk.sv
module lnk_frame_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] rx_sym,
    input logic        rx_ctl_lo,
    input logic        rx_ctl_hi,
    input logic        out_valid,
    input logic        out_sop,
    input logic        out_eop,
    input logic        out_err,
    input logic        xon_pulse,
    input logic        xoff_pulse,
    input logic        los_flag
);

    logic open_q;
    logic in_xon;
    logic in_los;

    assign in_xon = rx_ctl_hi && rx_ctl_lo && (rx_sym == 16'h5C5C);
    assign in_los = (rx_ctl_hi && rx_sym[15:8] == 8'hFF) || (rx_ctl_lo && rx_sym[7:0] == 8'hFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (out_valid) begin
            open_q <= !out_eop;
        end
    end

    // R3
    flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop || out_err) |-> out_valid);

    // R9
    err_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> out_eop);

    // R3
    sop_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sop == !open_q));

    // R6
    xon_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (xon_pulse == $past(in_xon)));

    // R6
    flow_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(xon_pulse && xoff_pulse));

    // R7
    los_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (los_flag == $past(in_los)));

endmodule

bind lnk_frame_rx lnk_frame_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_sym     (rx_sym),
    .rx_ctl_lo  (rx_ctl_lo),
    .rx_ctl_hi  (rx_ctl_hi),
    .out_valid  (out_valid),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_err    (out_err),
    .xon_pulse  (xon_pulse),
    .xoff_pulse (xoff_pulse),
    .los_flag   (los_flag)
);

// File: tb/lnk_frame_rx_bench.sv
module lnk_frame_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [17:0] S_START = {2'b11, 16'hDCDC};
    localparam logic [17:0] S_END   = {2'b11, 16'h9C9C};
    localparam logic [17:0] S_IDLE  = {2'b10, 16'hBCC5};
    localparam logic [17:0] S_XON   = {2'b11, 16'h5C5C};
    localparam logic [17:0] S_XOFF  = {2'b11, 16'h7C7C};
    localparam logic [17:0] S_LOS   = {2'b11, 16'hFFFF};
    localparam logic [17:0] S_ERRK  = {2'b11, 16'h0000};
    localparam logic [17:0] S_UNK   = {2'b11, 16'hFCFC};

    logic        clk;
    logic        rst_n;
    logic [15:0] rx_sym;
    logic        rx_ctl_lo;
    logic        rx_ctl_hi;
    logic [31:0] out_data;
    logic        out_valid, out_sop, out_eop, out_err;
    logic        xon_pulse, xoff_pulse, los_flag, link_err;

    lnk_frame_rx u_lnk_frame_rx (
        .clk(clk), .rst_n(rst_n), .rx_sym(rx_sym), .rx_ctl_lo(rx_ctl_lo), .rx_ctl_hi(rx_ctl_hi),
        .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
        .out_err(out_err), .xon_pulse(xon_pulse), .xoff_pulse(xoff_pulse),
        .los_flag(los_flag), .link_err(link_err)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [34:0] rec [0:63];
    int          rec_n, xon_n, xoff_n, los_n, lerr_n;
    logic [34:0] expq [0:63];
    int          exp_n;
    logic [17:0] stim [0:127];
    int          stim_n;
    int          body_idx;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (rec_n < 64) rec[rec_n] = {out_sop, out_eop, out_err, out_data};
                rec_n++;
            end
            if (xon_pulse)  xon_n++;
            if (xoff_pulse) xoff_n++;
            if (los_flag)   los_n++;
            if (link_err)   lerr_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [15:0] d);
        logic [15:0] r;
        r = c;
        for (int b = 15; b >= 0; b--) begin
            if (r[15] ^ d[b]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [31:0] wval(input int seed, input int k);
        return (32'h9E3779B9 * (seed + 1)) ^ (k * 32'h01020408) ^ 32'h00C5_BC00;
    endfunction

    task automatic push(input logic [17:0] s);
        stim[stim_n] = s;
        stim_n++;
    endtask

    task automatic push_body(input logic [17:0] s, input int ins_pos, input logic [17:0] ins);
        if (body_idx == ins_pos) push(ins);
        push(s);
        body_idx++;
    endtask

    task automatic add_exp(input bit sop, input bit eop, input bit err, input logic [31:0] d);
        expq[exp_n] = {sop, eop, err, d};
        exp_n++;
    endtask

    task automatic play();
        rec_n = 0; xon_n = 0; xoff_n = 0; los_n = 0; lerr_n = 0;
        for (int i = 0; i < stim_n; i++) begin
            @(negedge clk);
            {rx_ctl_hi, rx_ctl_lo, rx_sym} = stim[i];
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            {rx_ctl_hi, rx_ctl_lo, rx_sym} = S_IDLE;
        end
        @(negedge clk);
        stim_n = 0;
    endtask

    task automatic compare(input string req);
        chk(rec_n == exp_n, req, "word count", 64'(rec_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < rec_n; i++)
            chk(rec[i] == expq[i], req, "word {sop,eop,err,data}", 64'(rec[i]), 64'(expq[i]));
        exp_n = 0;
    endtask

    // good packet of L words; optional insertion and CRC bit flip
    task automatic good_pkt(input int seed, input int L, input int ins_pos,
                            input logic [17:0] ins, input int flip);
        logic [15:0] c;
        logic [31:0] w;
        c = 16'hFFFF;
        body_idx = 0;
        push(S_START);
        for (int k = 0; k < L; k++) begin
            w = wval(seed, k);
            push_body({2'b00, w[15:0]}, ins_pos, ins);
            push_body({2'b00, w[31:16]}, ins_pos, ins);
            c = crc_ref(crc_ref(c, w[15:0]), w[31:16]);
            add_exp(k == 0, k == L - 1, (k == L - 1) && (flip >= 0), w);
        end
        push_body(S_END, ins_pos, ins);
        if (flip >= 0) c = c ^ (16'h1 << flip);
        push_body({2'b00, c}, ins_pos, ins);
        if (body_idx == ins_pos) push(ins);
    endtask

    // k words, optional odd half, then the aborting symbol and stray data
    task automatic abort_pkt(input int seed, input int k, input bit odd, input logic [17:0] bad);
        logic [31:0] w;
        push(S_START);
        for (int j = 0; j < k; j++) begin
            w = wval(seed, j);
            push({2'b00, w[15:0]});
            push({2'b00, w[31:16]});
            if (j < k - 1) add_exp(j == 0, 1'b0, 1'b0, w);
            else           add_exp(j == 0, 1'b1, 1'b1, w);
        end
        if (odd) push({2'b00, 16'h1234});
        push(bad);
        push({2'b00, 16'hAAAA});
        push({2'b00, 16'h5555});
        push(S_END);
        push({2'b00, 16'h0F0F});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rec_n = 0; xon_n = 0; xoff_n = 0; los_n = 0; lerr_n = 0;
        exp_n = 0; stim_n = 0; body_idx = 0;
        rst_n = 1'b0;
        {rx_ctl_hi, rx_ctl_lo, rx_sym} = S_XON;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R11: outputs held low in reset even with a flow code on the input
            chk({out_valid, out_sop, out_eop, out_err, xon_pulse, xoff_pulse, los_flag, link_err,
                 out_data} == '0, "R11", "reset outputs",
                64'({out_valid, xon_pulse, out_data}), 64'(0));
        end
        {rx_ctl_hi, rx_ctl_lo, rx_sym} = S_IDLE;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R3 R4: packet length sweep
        for (int L = 1; L <= 6; L++) begin
            good_pkt(L, L, -1, S_IDLE, -1);
            play();
            compare("R2/R3 length sweep");
        end

        // R5: idle at every position inside a packet
        for (int p = 0; p <= 8; p++) begin
            good_pkt(10 + p, 3, p, S_IDLE, -1);
            play();
            compare("R5 idle skip");
        end

        // R6: flow codes at every position
        for (int p = 0; p <= 8; p++) begin
            good_pkt(20 + p, 3, p, (p % 2 == 1) ? S_XON : S_XOFF, -1);
            play();
            compare("R6 flow code in packet");
            chk(xon_n == (p % 2), "R6", "xon pulses", 64'(xon_n), 64'(p % 2));
            chk(xoff_n == 1 - (p % 2), "R6", "xoff pulses", 64'(xoff_n), 64'(1 - p % 2));
        end

        // R4: every CRC bit flipped
        for (int b = 0; b < 16; b++) begin
            good_pkt(40 + b, 2, -1, S_IDLE, b);
            play();
            compare("R4 crc flip");
        end

        // R1: stray symbols while hunting
        push({2'b00, 16'h1111}); push({2'b00, 16'h2222}); push(S_END); push({2'b00, 16'h3333});
        play();
        compare("R1 hunt discard");

        // R10: empty packet
        push(S_START); push(S_END); push({2'b00, 16'h1D0F});
        play();
        compare("R10 empty packet");

        // R9: start inside packet, even and odd half counts
        abort_pkt(60, 2, 1'b0, S_START); play(); compare("R9 start even");
        abort_pkt(61, 1, 1'b1, S_START); play(); compare("R9 start odd");
        // R9: end after an odd half count
        abort_pkt(62, 2, 1'b1, S_END);   play(); compare("R9 end odd");
        // R8 R9: unknown control code in packet
        abort_pkt(63, 3, 1'b0, S_UNK);   play(); compare("R9 unknown code");
        chk(lerr_n == 1, "R8", "link_err unknown", 64'(lerr_n), 64'(1));
        // R8 R9: error code in packet
        abort_pkt(64, 1, 1'b0, S_ERRK);  play(); compare("R9 error code");
        chk(lerr_n == 1, "R8", "link_err K0.0", 64'(lerr_n), 64'(1));
        // R7 R9: loss of signal in packet
        abort_pkt(65, 2, 1'b1, S_LOS);   play(); compare("R7/R9 los in packet");
        chk(los_n == 1, "R7", "los in packet", 64'(los_n), 64'(1));

        // R7 R8: alarms while hunting, single-lane codes
        push({2'b10, 16'hFFC5}); push({2'b01, 16'h3300}); push(S_UNK);
        play();
        compare("R7/R8 hunt alarms");
        chk(los_n == 1, "R7", "los in hunt", 64'(los_n), 64'(1));
        chk(lerr_n == 2, "R8", "link_err in hunt", 64'(lerr_n), 64'(2));

        // R9: recovery after abort
        good_pkt(70, 2, -1, S_IDLE, -1);
        play();
        compare("R9 recovery");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule